// File: doc/BRIEF.md
# Timebase-Tap Staged Watchdog

This block is a per-core watchdog that does not count down on its own. A free-running timebase counter advances on every cycle in which the tick input is high. A period field in the control register picks one bit of that counter. Each 0-to-1 transition of the picked bit is one watchdog event. A larger period value picks a less significant bit, so events come sooner.

Events that software leaves unserviced escalate through three stages. The first event only records an "armed" status bit. The second event sets an interrupt-pending bit, and that bit drives a level interrupt when interrupts are enabled. The third event requests a reset according to a reset-action field. The reset-action field can be written only once. Software services the watchdog by writing ones to the status bits, which returns the escalation to its first stage.

Registers are reached through a single-cycle write port and a combinational read port. Each port has a one-bit register select: 0 selects the control register and 1 selects the status register.

Top module: `wdog_stage`

## Requirements
- R1: After rst_ni is released, the control and status registers both read zero, irq_o and rst_req_o are low, and the timebase is zero.
- R2: The timebase increments by one in every cycle where tb_tick_i is high. A period value p (control bits [5:0] at the default 64-bit timebase) selects timebase bit 63-p. An event occurs on each 0-to-1 change of that bit, so events are 2^(64-p) ticks apart.
- R3: Events escalate in order. When status bit 0 (armed) is clear, an event sets it. When armed is set and status bit 1 (pending) is clear, an event sets pending. When both are set, an event takes the reset action.
- R4: irq_o is high exactly while pending is set and control bit 8 (interrupt enable) is set. Writing the enable bit changes irq_o with no new event.
- R5: The reset-action field, control bits [13:12], accepts a write only while it holds zero. Once it is non-zero, later writes leave it unchanged until rst_ni.
- R6: A reset action with a non-zero field drives rst_req_o high for exactly one cycle and copies the field into status bits [5:4] (last cause). With a zero field there is no pulse and the cause does not change.
- R7: Writing the status register clears each of bits 0 and 1 where the written data has a one. Writing ones to both returns escalation to the first stage. The cause field is read-only.
- R8: A control write suppresses event detection in the following cycle, so changing the period never produces a spurious event.
- R9: With period 0 and interrupts disabled, the watchdog is neutralised. Bit 63 is tapped, and status and irq_o stay quiet over long tick runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tb_tick_i | input | 1 | Timebase advance strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control, 1 status |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read target: 0 control, 1 status |
| rd_data_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Level watchdog interrupt |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The bench checks every tick against its own timebase and stage model. A design that taps the wrong bit, or reacts to falling edges, drifts from the model within a few ticks.

The bench steers the timebase to a value where the old tapped bit is 0 and the new one is 1, then changes the period. A design without the suppression cycle would set the armed bit from nothing.

The bench tries to overwrite a non-zero reset action and expects the old value to stay. It runs a third event with a zero action and expects no pulse. It also toggles the interrupt enable while pending is set; a design that edge-latches the interrupt would leave irq_o wrong there.

// File: rtl/wdt_stage_pkg.sv
package wdt_stage_pkg;
   // control register field positions
   localparam int CTL_PER_LSB  = 0;
   localparam int CTL_IE_BIT   = 8;
   localparam int CTL_ACT_LSB  = 12;
   // status register field positions
   localparam int ST_ARM_BIT   = 0;
   localparam int ST_PEND_BIT  = 1;
   localparam int ST_CAUSE_LSB = 4;

   typedef enum logic {
      REG_CTL = 1'b0,
      REG_ST  = 1'b1
   } wdt_reg_e;
endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
   parameter int TB_W = 64
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            tick_i,
   output logic [TB_W-1:0] tb_o
);
   logic [TB_W-1:0] tb_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     tb_q <= '0;
      else if (tick_i) tb_q <= tb_q + 1'b1;
   end

   assign tb_o = tb_q;
endmodule

// File: rtl/wdt_tap_edge.sv
module wdt_tap_edge #(
   parameter int TB_W = 64,
   parameter int PW   = $clog2(TB_W)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [TB_W-1:0] tb_i,
   input  logic [PW-1:0]   period_i,
   input  logic            hold_i,
   output logic            event_o
);
   localparam logic [PW-1:0] TOP_IDX = PW'(TB_W - 1);

   logic [PW-1:0] idx;
   logic          tap;
   logic          prev_q;
   logic          armed_q;

   // larger period value -> less significant bit
   assign idx = TOP_IDX - period_i;
   assign tap = tb_i[idx];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         prev_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         prev_q  <= tap;
         armed_q <= !hold_i;
      end
   end

   // one cycle blanked after a control write: prev_q may hold a bit of the old tap
   assign event_o = armed_q && tap && !prev_q;
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate #(
   parameter int ACT_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             event_i,
   input  logic [1:0]       clr_i,
   input  logic [ACT_W-1:0] act_i,
   output logic             arm_o,
   output logic             pend_o,
   output logic [ACT_W-1:0] cause_o,
   output logic             rst_req_o
);
   logic             arm_q, pend_q, req_q;
   logic [ACT_W-1:0] cause_q;
   logic             arm_d, pend_d, req_d;
   logic [ACT_W-1:0] cause_d;

   always_comb begin
      arm_d   = arm_q  & ~clr_i[0];
      pend_d  = pend_q & ~clr_i[1];
      cause_d = cause_q;
      req_d   = 1'b0;
      if (event_i) begin
         if (!arm_d)              arm_d  = 1'b1;
         else if (!pend_d)        pend_d = 1'b1;
         else if (act_i != '0) begin
            req_d   = 1'b1;
            cause_d = act_i;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         arm_q   <= 1'b0;
         pend_q  <= 1'b0;
         cause_q <= '0;
         req_q   <= 1'b0;
      end else begin
         arm_q   <= arm_d;
         pend_q  <= pend_d;
         cause_q <= cause_d;
         req_q   <= req_d;
      end
   end

   assign arm_o     = arm_q;
   assign pend_o    = pend_q;
   assign cause_o   = cause_q;
   assign rst_req_o = req_q;
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage #(
   parameter int TB_W  = 64,
   parameter int ACT_W = 2,
   parameter int DW    = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          tb_tick_i,
   input  logic          wr_en_i,
   input  logic          wr_sel_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          rd_sel_i,
   output logic [DW-1:0] rd_data_o,
   output logic          irq_o,
   output logic          rst_req_o
);
   import wdt_stage_pkg::*;

   localparam int PW = $clog2(TB_W);

   // elaboration-time parameter checks
   if (TB_W < 4 || TB_W != (1 << PW)) begin : g_bad_tbw
      $error("TB_W must be a power of two of at least 4");
   end
   if (PW > CTL_IE_BIT) begin : g_bad_pw
      $error("period field overlaps the interrupt enable bit");
   end
   if (ACT_W < 1 || ACT_W > 4 || CTL_ACT_LSB + ACT_W > DW) begin : g_bad_act
      $error("reset action field does not fit the register width");
   end

   logic [TB_W-1:0]  tb;
   logic [PW-1:0]    per_q;
   logic             ie_q;
   logic [ACT_W-1:0] act_q;
   logic             ctl_wr, st_wr;
   logic [1:0]       clr;
   logic             tap_event;
   logic             arm, pend;
   logic [ACT_W-1:0] cause;

   assign ctl_wr = wr_en_i && (wr_sel_i == REG_CTL);
   assign st_wr  = wr_en_i && (wr_sel_i == REG_ST);
   assign clr    = st_wr ? {wr_data_i[ST_PEND_BIT], wr_data_i[ST_ARM_BIT]} : 2'b00;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         per_q <= '0;
         ie_q  <= 1'b0;
         act_q <= '0;
      end else if (ctl_wr) begin
         per_q <= wr_data_i[CTL_PER_LSB +: PW];
         ie_q  <= wr_data_i[CTL_IE_BIT];
         if (act_q == '0) act_q <= wr_data_i[CTL_ACT_LSB +: ACT_W];
      end
   end

   wdt_timebase #(.TB_W(TB_W)) u_tb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tb_tick_i),
      .tb_o   (tb)
   );

   wdt_tap_edge #(.TB_W(TB_W), .PW(PW)) u_tap (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tb_i     (tb),
      .period_i (per_q),
      .hold_i   (ctl_wr),
      .event_o  (tap_event)
   );

   wdt_escalate #(.ACT_W(ACT_W)) u_esc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .event_i   (tap_event),
      .clr_i     (clr),
      .act_i     (act_q),
      .arm_o     (arm),
      .pend_o    (pend),
      .cause_o   (cause),
      .rst_req_o (rst_req_o)
   );

   assign irq_o = pend & ie_q;

   always_comb begin
      rd_data_o = '0;
      if (rd_sel_i == REG_CTL) begin
         rd_data_o[CTL_PER_LSB +: PW]    = per_q;
         rd_data_o[CTL_IE_BIT]           = ie_q;
         rd_data_o[CTL_ACT_LSB +: ACT_W] = act_q;
      end else begin
         rd_data_o[ST_ARM_BIT]            = arm;
         rd_data_o[ST_PEND_BIT]           = pend;
         rd_data_o[ST_CAUSE_LSB +: ACT_W] = cause;
      end
   end
endmodule

// File: rtl/wdog_stage_chk.sv
module wdog_stage_chk #(
   parameter int ACT_W = 2
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             wr_en_i,
   input logic             wr_sel_i,
   input logic             tap_event,
   input logic             arm,
   input logic             pend,
   input logic [ACT_W-1:0] act_q,
   input logic [ACT_W-1:0] cause,
   input logic             rst_req_o
);
   // R6: the reset request lasts a single cycle
   a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_o |=> !rst_req_o);

   // R3: a reset request only follows an event seen with both stages set
   a_r3_reset_needs_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_o |-> $past(arm && pend && tap_event));

   // R3: pending rises only when armed was already set
   a_r3_pend_after_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend) |-> $past(arm));

   // R5: a non-zero reset action never changes
   a_r5_action_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(act_q) != '0) |-> (act_q == $past(act_q)));

   // R8: no event in the cycle after a control write
   a_r8_no_event_after_ctl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(wr_en_i && !wr_sel_i) |-> !tap_event);

   // R6: the last cause moves only together with a reset request
   a_r6_cause_with_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(cause) |-> rst_req_o);
endmodule

bind wdog_stage wdog_stage_chk #(.ACT_W(ACT_W)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .wr_en_i   (wr_en_i),
   .wr_sel_i  (wr_sel_i),
   .tap_event (tap_event),
   .arm       (arm),
   .pend      (pend),
   .act_q     (act_q),
   .cause     (cause),
   .rst_req_o (rst_req_o)
);

// File: tb/wdog_stage_bench.sv
module wdog_stage_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_sel = 1'b0;
   logic [31:0] rd_data;
   logic        irq;
   logic        rst_req;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // bench model
   logic [63:0] tb_m;
   logic [5:0]  per_m;
   bit          ie_m;
   logic [1:0]  act_m, cause_m;
   bit          arm_m, pend_m;
   int          rst_seen = 0;
   int          rst_exp = 0;

   always #2 clk = ~clk;   // 250 MHz

   wdog_stage u_wdog_stage (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .tb_tick_i (tick),
      .wr_en_i   (wr_en),
      .wr_sel_i  (wr_sel),
      .wr_data_i (wr_data),
      .rd_sel_i  (rd_sel),
      .rd_data_o (rd_data),
      .irq_o     (irq),
      .rst_req_o (rst_req)
   );

   always @(negedge clk) if (rst_n && rst_req) rst_seen++;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic rd(input logic sel, output logic [31:0] v);
      rd_sel = sel;
      #1;
      v = rd_data;
   endtask

   task automatic check_state(input string req);
      logic [31:0] v;
      rd(1'b1, v);
      chk(req, "status", v, {26'b0, cause_m, 2'b0, pend_m, arm_m});
      chk(req, "irq", {31'b0, irq}, {31'b0, pend_m & ie_m});
      chk(req, "reset pulses", rst_seen, rst_exp);
   endtask

   task automatic check_ctl(input string req);
      logic [31:0] v;
      rd(1'b0, v);
      chk(req, "control", v, {18'b0, act_m, 3'b0, ie_m, 2'b0, per_m});
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (!sel) begin
         per_m = d[5:0];
         ie_m  = d[8];
         if (act_m == 2'b0) act_m = d[13:12];
      end else begin
         if (d[0]) arm_m  = 1'b0;
         if (d[1]) pend_m = 1'b0;
      end
   endtask

   function automatic logic [31:0] ctl(input int per, input bit ie, input int act);
      return (32'(act) << 12) | (32'(ie) << 8) | 32'(per);
   endfunction

   task automatic do_tick(input string req);
      logic [63:0] old;
      int k;
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
      old  = tb_m;
      tb_m = tb_m + 64'd1;
      k    = 63 - int'(per_m);
      if (!old[k] && tb_m[k]) begin
         if (!arm_m)               arm_m  = 1'b1;
         else if (!pend_m)         pend_m = 1'b1;
         else if (act_m != 2'b0) begin
            rst_exp++;
            cause_m = act_m;
         end
      end
      check_state(req);
   endtask

   task automatic apply_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tb_m = '0; per_m = '0; ie_m = 1'b0; act_m = '0; cause_m = '0;
      arm_m = 1'b0; pend_m = 1'b0;
   endtask

   // R1
   task automatic t_reset();
      apply_reset();
      check_state("R1");
      check_ctl("R1");
      chk("R1", "rst_req", {31'b0, rst_req}, 32'd0);
   endtask

   // R2, R3, R4, R6: escalate to reset with tap bit 1
   task automatic t_escalate();
      wr(1'b0, ctl(62, 1, 2));
      check_ctl("R2");
      for (int i = 0; i < 10; i++) do_tick("R3");
      chk("R6", "cause after third event", {30'b0, cause_m}, 32'd2);
      chk("R6", "one reset pulse", rst_seen, 1);
      @(negedge clk); #1;
      chk("R6", "rst_req low after pulse", {31'b0, rst_req}, 32'd0);
   endtask

   // R5
   task automatic t_write_once();
      wr(1'b0, ctl(62, 1, 1));
      check_ctl("R5");
   endtask

   // R7
   task automatic t_ping();
      wr(1'b1, 32'h3);
      check_state("R7");
      for (int i = 0; i < 8; i++) do_tick("R7");
      wr(1'b1, 32'h2);
      check_state("R7");
   endtask

   // R4: level interrupt gated by enable
   task automatic t_irq_gate();
      wr(1'b1, 32'h3);
      wr(1'b0, ctl(62, 0, 0));
      for (int i = 0; i < 8; i++) do_tick("R4");
      wr(1'b0, ctl(62, 1, 0));
      check_state("R4");
      repeat (3) @(negedge clk);
      check_state("R4");
      wr(1'b1, 32'h2);
      check_state("R4");
   endtask

   // R2: other tap position
   task automatic t_period_tap();
      wr(1'b1, 32'h3);
      wr(1'b0, ctl(61, 1, 0));
      for (int i = 0; i < 17; i++) do_tick("R2");
   endtask

   // R8: period change onto a bit that is already high
   task automatic t_period_switch();
      wr(1'b0, ctl(0, 1, 0));
      wr(1'b1, 32'h3);
      while (tb_m[1:0] != 2'b10) do_tick("R8");
      wr(1'b0, ctl(62, 1, 0));
      repeat (3) @(negedge clk);
      check_state("R8");
   endtask

   // R9
   task automatic t_neutral();
      wr(1'b0, ctl(0, 0, 0));
      wr(1'b1, 32'h3);
      for (int i = 0; i < 40; i++) do_tick("R9");
   endtask

   // R6 zero action, R5 write accepted while zero
   task automatic t_zero_action();
      apply_reset();
      check_state("R1");
      wr(1'b0, ctl(63, 1, 0));
      for (int i = 0; i < 6; i++) do_tick("R6");
      wr(1'b0, ctl(63, 1, 3));
      check_ctl("R5");
      for (int i = 0; i < 2; i++) do_tick("R6");
      chk("R6", "cause after late action", {30'b0, cause_m}, 32'd3);
   endtask

   initial begin
      t_reset();
      t_escalate();
      t_write_once();
      t_ping();
      t_irq_gate();
      t_period_tap();
      t_period_switch();
      t_neutral();
      t_zero_action();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule